// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single-master external bus cycles on a shared 16-bit address/data path plus four upper lines that carry high address bits or status. An internal requester presents a read or write with a 16-bit segment base, a 16-bit offset, a byte or word size and a two-bit segment code. The block forms the 20-bit physical address by shifting the base left four places and adding the offset, modulo 2^20. It then sequences the cycle: an address phase marked by a latch-enable pulse, a strobe phase, optional wait states and a closing state.

The sequencer is built around six named states. ST_IDLE waits for a request. ST_T1 drives the address. ST_T2 turns the data path around and asserts the strobe, and ST_T3 holds the strobe and samples ready. ST_TW is a wait state that samples ready again. ST_T4 releases the strobe and reports completion. The transitions are:
- ST_IDLE→ST_T1 on an accepted request.
- ST_T1→ST_T2→ST_T3 unconditionally.
- ST_T3→ST_T4 or ST_TW→ST_T4 when ready is high.
- ST_T3→ST_TW or ST_TW→ST_TW when ready is low.
- ST_T4→ST_IDLE.

Byte lanes follow the address bit 0 and the size. The upper-byte enable is driven in the address phase only. Read data is returned right-aligned.

Top module: `mux_bus_seq`

## Requirements
- R1: While rst_n is low and afterwards until a request is accepted: req_ack=1, ale=0, rd_n=1, wr_n=1, bhe_n=1, ad_oe=0, done=0.
- R2: When req_valid is high while req_ack is high, the next cycle is the address phase. In it, ale=1, ad_out equals physical address bits 15..0 and a_hi equals bits 19..16, where address = (segment*16 + offset) mod 2^20. ale is high for exactly that one cycle of the bus cycle.
- R3: After the address phase and until the cycle ends, a_hi carries status. a_hi[3] is 0. a_hi[2] is the interrupt-enable input captured at acceptance. a_hi[1:0] is the segment code captured at acceptance: 00 extra, 01 stack, 10 code or none, 11 data.
- R4: In the address phase, bhe_n=0 when the access is a word, or a byte whose address bit 0 is 1. bhe_n=1 for a byte with address bit 0 equal to 0. In every other cycle, bhe_n=1.
- R5: For a read, rd_n=0 in the two strobe states and in every wait state, and rd_n=1 otherwise. ad_oe=0 from the state after the address phase to the end of the cycle, and wr_n stays 1.
- R6: For a write, wr_n=0 in the two strobe states and in every wait state, and rd_n stays 1. ad_oe=1 for the whole cycle. After the address phase, ad_out carries the write data: all 16 bits for a word, and for a byte the low write-data byte copied onto both lanes.
- R7: ready is sampled on the edge that ends the second strobe state and on the edge that ends each wait state. Each low sample adds one wait state. The closing state follows the first high sample, and done is high for exactly that one cycle.
- R8: On the closing edge, rd_data captures ad_in for a word, ad_in[7:0] zero-extended for an even byte, and ad_in[15:8] zero-extended for an odd byte. rd_data holds this value until the next read completes.
- R9: req_ack is low from the address phase through the closing state. Changes on the request inputs while req_ack is low have no effect on the cycle in progress. After the closing state the block returns to idle for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_seg | input | 2 | Segment code for status |
| req_segment | input | 16 | Segment base |
| req_offset | input | 16 | Offset within segment |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| int_en | input | 1 | Interrupt-enable flag for status |
| req_ack | output | 1 | Idle; request taken when req_valid is also high |
| done | output | 1 | One-cycle pulse in closing state |
| rd_data | output | 16 | Captured read data |
| ready | input | 1 | Wait-state control, low stretches the cycle |
| ad_in | input | 16 | Shared path, incoming value |
| ad_out | output | 16 | Shared path, driven value |
| ad_oe | output | 1 | Drive enable for ad_out |
| a_hi | output | 4 | Address bits 19..16 or status |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | Upper-byte enable, active low (reads 1 as status) |

## Verification
The assertions assume that ready is a clean level at each rising edge and that requests arrive only through req_valid with req_ack high. They also assume ad_in is stable across the sampling edge. The stimulus changes every input at the falling edge and holds ad_in constant for a whole cycle. Word accesses are issued only at even addresses. The sweep scrambles the request fields after acceptance so that latching is exercised.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_code_e;

endpackage

// File: rtl/mux_bus_addr.sv
module mux_bus_addr #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20
) (
    input  logic [SEG_W-1:0]  segment,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] phys
);
    localparam int BASE_W = SEG_W + SHIFT;
    localparam int OPAD   = ADDR_W - OFF_W;

    logic [BASE_W-1:0] base;

    always_comb begin
        base = {segment, {SHIFT{1'b0}}};
        phys = base[ADDR_W-1:0] + {{OPAD{1'b0}}, offset};
    end
endmodule

// File: rtl/mux_bus_lane.sv
module mux_bus_lane #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word,
    input  logic              a0,
    input  logic              capture,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              hi_en,
    output logic [DATA_W-1:0] wr_bus,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        hi_en = word | a0;
        if (word) begin
            wr_bus  = wdata;
            rd_next = ad_in;
        end else begin
            wr_bus = {2{wdata[HALF-1:0]}};
            if (a0) rd_next = {{HALF{1'b0}}, ad_in[DATA_W-1:HALF]};
            else    rd_next = {{HALF{1'b0}}, ad_in[HALF-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= rd_next;
    end
endmodule

// File: rtl/mux_bus_fsm.sv
module mux_bus_fsm
    import mux_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ready,
    output bus_state_e state,
    output logic       finish
);
    bus_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_T3;
            ST_T3, ST_TW: begin
                if (ready) begin
                    state_nx = ST_T4;
                    finish   = 1'b1;
                end else begin
                    state_nx = ST_TW;
                end
            end
            ST_T4:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mux_bus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 16,
    parameter int SHIFT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [1:0]        req_seg,
    input  logic [SEG_W-1:0]  req_segment,
    input  logic [DATA_W-1:0] req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              int_en,
    output logic              req_ack,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [SHIFT-1:0]  a_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              bhe_n
);
    localparam int ADDR_W = DATA_W + SHIFT;

    bus_state_e        state;
    logic              start, finish;
    logic              q_write, q_word, q_ie;
    logic [1:0]        q_seg;
    logic [SEG_W-1:0]  q_segment;
    logic [DATA_W-1:0] q_offset, q_wdata;
    logic [ADDR_W-1:0] phys;
    logic              hi_en;
    logic [DATA_W-1:0] wr_bus;
    logic [SHIFT-1:0]  status;

    assign start = req_valid && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write   <= 1'b0;
            q_word    <= 1'b0;
            q_ie      <= 1'b0;
            q_seg     <= SEG_CODE;
            q_segment <= '0;
            q_offset  <= '0;
            q_wdata   <= '0;
        end else if (start) begin
            q_write   <= req_write;
            q_word    <= req_word;
            q_ie      <= int_en;
            q_seg     <= req_seg;
            q_segment <= req_segment;
            q_offset  <= req_offset;
            q_wdata   <= req_wdata;
        end
    end

    mux_bus_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .ready  (ready),
        .state  (state),
        .finish (finish)
    );

    mux_bus_addr #(
        .SEG_W  (SEG_W),
        .OFF_W  (DATA_W),
        .SHIFT  (SHIFT),
        .ADDR_W (ADDR_W)
    ) addr_i (
        .segment (q_segment),
        .offset  (q_offset),
        .phys    (phys)
    );

    mux_bus_lane #(.DATA_W(DATA_W)) lane_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .word    (q_word),
        .a0      (phys[0]),
        .capture (finish && !q_write),
        .wdata   (q_wdata),
        .ad_in   (ad_in),
        .hi_en   (hi_en),
        .wr_bus  (wr_bus),
        .rd_data (rd_data)
    );

    // Status layout on the upper lines: [top]=0, then interrupt enable, then segment code.
    always_comb begin
        status = '0;
        status[SHIFT-2]   = q_ie;
        status[1:0]       = q_seg;
    end

    always_comb begin
        req_ack = 1'b0;
        done    = 1'b0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        bhe_n   = 1'b1;
        ad_oe   = 1'b0;
        ad_out  = '0;
        a_hi    = '0;
        unique case (state)
            ST_IDLE: req_ack = 1'b1;
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = phys[DATA_W-1:0];
                a_hi   = phys[ADDR_W-1:DATA_W];
                bhe_n  = !hi_en;
            end
            ST_T2, ST_T3, ST_TW: begin
                a_hi   = status;
                ad_oe  = q_write;
                ad_out = q_write ? wr_bus : '0;
                rd_n   = q_write;
                wr_n   = !q_write;
            end
            ST_T4: begin
                done   = 1'b1;
                a_hi   = status;
                ad_oe  = q_write;
                ad_out = q_write ? wr_bus : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
    parameter int DATA_W = 16,
    parameter int SHIFT  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ack,
    input logic              done,
    input logic              ready,
    input logic              ad_oe,
    input logic [SHIFT-1:0]  a_hi,
    input logic              ale,
    input logic              rd_n,
    input logic              wr_n,
    input logic              bhe_n
);
    a_r2_ale_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> ale);

    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r3_s6_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (a_hi[SHIFT-1] == 1'b0));

    a_r4_bhe_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        !bhe_n |-> ale);

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    a_r7_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ready));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (rd_n && wr_n && !ale && !done));
endmodule

bind mux_bus_seq mux_bus_seq_chk #(.DATA_W(DATA_W), .SHIFT(SHIFT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .done      (done),
    .ready     (ready),
    .ad_oe     (ad_oe),
    .a_hi      (a_hi),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bhe_n     (bhe_n)
);

// File: tb/mux_bus_seq_tb_top.sv
`timescale 1ns/1ps
module mux_bus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [1:0]  req_seg = 2'b00;
    logic [15:0] req_segment = '0, req_offset = '0, req_wdata = '0;
    logic        int_en = 1'b0;
    logic        req_ack, done;
    logic [15:0] rd_data;
    logic        ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  a_hi;
    logic        ale, rd_n, wr_n, bhe_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mux_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_seg(req_seg), .req_segment(req_segment),
        .req_offset(req_offset), .req_wdata(req_wdata), .int_en(int_en),
        .req_ack(req_ack), .done(done), .rd_data(rd_data), .ready(ready),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_checks(input string tag);
        chk(req_ack == 1'b1, {tag, " req_ack"}, req_ack, 1);
        chk(ale == 1'b0 && rd_n && wr_n && bhe_n && !ad_oe && !done,
            {tag, " idle outputs"}, {ale, rd_n, wr_n, bhe_n, ad_oe, done}, 6'b011100);
    endtask

    task automatic run_cycle(input bit wr, input bit wd, input logic [1:0] sg,
                             input logic [15:0] sbase, input logic [15:0] off,
                             input logic [15:0] wdat, input bit ie, input int waits,
                             input logic [15:0] pat);
        logic [19:0] pa;
        logic [3:0]  st;
        logic [15:0] wexp, rexp;
        pa   = ({sbase, 4'h0} + {4'h0, off});
        st   = {1'b0, ie, sg};
        wexp = wd ? wdat : {wdat[7:0], wdat[7:0]};
        rexp = wd ? pat : (off[0] ? {8'h00, pat[15:8]} : {8'h00, pat[7:0]});

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_seg = sg;
        req_segment = sbase; req_offset = off; req_wdata = wdat; int_en = ie;
        ready = 1'b1; ad_in = pat;
        #1 chk(req_ack == 1'b1, "R9 ack before accept", req_ack, 1);

        // address phase; scramble request inputs
        @(negedge clk);
        req_valid = 1'b0; req_segment = ~sbase; req_offset = ~off; req_wdata = ~wdat;
        req_seg = ~sg; int_en = ~ie; req_word = ~wd; req_write = ~wr;
        #1;
        chk(ale == 1'b1, "R2 ale in address phase", ale, 1);
        chk(ad_out == pa[15:0] && ad_oe, "R2 low address", ad_out, pa[15:0]);
        chk(a_hi == pa[19:16], "R2 high address", a_hi, pa[19:16]);
        chk(bhe_n == !(wd || off[0]), "R4 bhe in address phase", bhe_n, !(wd || off[0]));
        chk(req_ack == 1'b0, "R9 ack low in cycle", req_ack, 0);

        for (int ph = 0; ph < 2 + waits; ph++) begin
            @(negedge clk);
            if (ph == 1) ready = (waits == 0);
            else if (ph >= 2) ready = (ph - 2 == waits - 1);
            #1;
            chk(ale == 1'b0, "R2 ale low after address", ale, 0);
            chk(a_hi == st, "R3 status lines", a_hi, st);
            chk(bhe_n == 1'b1, "R4 bhe high outside address", bhe_n, 1);
            chk(done == 1'b0, "R7 no done while strobing", done, 0);
            chk(req_ack == 1'b0, "R9 ack low in cycle", req_ack, 0);
            if (wr) begin
                chk(!wr_n && rd_n, "R6 write strobe", {wr_n, rd_n}, 2'b01);
                chk(ad_oe && ad_out == wexp, "R6 write data", ad_out, wexp);
            end else begin
                chk(!rd_n && wr_n, "R5 read strobe", {rd_n, wr_n}, 2'b01);
                chk(!ad_oe, "R5 path released", ad_oe, 0);
            end
        end

        // closing state
        @(negedge clk);
        ready = 1'b1; ad_in = ~pat;
        #1;
        chk(done == 1'b1, "R7 done in closing state", done, 1);
        chk(rd_n && wr_n, "R7 strobes released", {rd_n, wr_n}, 2'b11);
        chk(a_hi == st, "R3 status in closing", a_hi, st);
        chk(ad_oe == wr, "R5 R6 drive in closing", ad_oe, wr);
        if (wr) chk(ad_out == wexp, "R6 write data held", ad_out, wexp);
        else    chk(rd_data == rexp, "R8 read data", rd_data, rexp);

        @(negedge clk);
        #1 idle_checks("R9 back to idle");
        chk(done == 1'b0, "R7 done single pulse", done, 0);
        if (!wr) chk(rd_data == rexp, "R8 read data held", rd_data, rexp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #1 idle_checks("R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 idle_checks("R1 after reset");
        chk(rd_data == 16'h0, "R1 read data reset", rd_data, 0);

        n = 0;
        for (int wr = 0; wr < 2; wr++)
            for (int wd = 0; wd < 2; wd++)
                for (int odd = 0; odd < 2; odd++)
                    for (int sg = 0; sg < 4; sg++)
                        for (int w = 0; w < 3; w++)
                            for (int ie = 0; ie < 2; ie++) begin
                                logic [15:0] sb, of, wdv, pt;
                                if (wd == 1 && odd == 1) continue;
                                n++;
                                sb  = 16'(n * 16'h0A37) ^ 16'hF00F;
                                of  = (16'(n * 16'h1357) & 16'hFFFE) | 16'(odd);
                                wdv = 16'(n * 16'h4B27) ^ 16'h1C3E;
                                pt  = 16'(n * 16'h2F1D) ^ 16'hA5C3;
                                run_cycle(wr[0], wd[0], sg[1:0], sb, of, wdv, ie[0], w, pt);
                            end

        // wrap-around of the 20-bit address (R2), long wait run (R7)
        run_cycle(1'b0, 1'b1, 2'b11, 16'hFFFF, 16'h0020, 16'h0, 1'b1, 5, 16'hBEEF);
        run_cycle(1'b1, 1'b0, 2'b01, 16'hFFF8, 16'hFF81, 16'h00A7, 1'b0, 4, 16'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule